// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block owns the control address register of a microprogrammed control unit. Each clock it looks at the microinstruction currently read out of the control store and decides where the next one comes from. The choice can be the branch target carried in the word, the following address, a single saved return address, or a dispatch slot derived from the macroinstruction opcode. The register value drives the control store address directly, so a store read combinationally from `car` closes the loop in one cycle per microinstruction.

Each microinstruction is 20 bits wide. The low 7 bits are the branch target. The next 2 bits up are the sequencing mode, and the 2 bits above those are the condition select. The top 9 bits hold three micro-operation fields. Those fields belong to decoders elsewhere, and this block does not use them. A condition multiplexer chooses one of four sources: always true, the indirect mode bit, the sign flag or the zero flag. Each sequencing mode then uses that condition in its own way. One return register provides a single level of subroutine nesting.

Top module: `uprog_sequencer`

## Requirements
- R1: A synchronous reset clears the control address to 0 and clears the return register to 0, so a return taken straight after reset goes to address 0.
- R2: The micro-operation fields in bits 19..11 have no effect on sequencing.
- R3: A condition select (bits 10..9) of 00 always counts as true.
- R4: A condition select of 01 tests `ind_bit`, 10 tests `sign_flag` and 11 tests `zero_flag`.
- R5: Mode 00 (bits 8..7) is a jump. When the condition is true, the next address is the target in bits 6..0. When it is false, the next address is the current address plus one.
- R6: Mode 01 is a call. When the condition is true, the next address is the target and the return register loads the current address plus one. When it is false, the next address is the current address plus one and the return register keeps its value.
- R7: Mode 10 is a return. The next address is the return register's contents, whatever the condition and the target field hold.
- R8: Mode 11 is a dispatch. Whatever the condition, the next address is {0, opcode[3:0], 00}, so each opcode owns a 4-word slot.
- R9: The address increment wraps from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uinstr | input | 20 | Microinstruction read from the control store at `car` |
| opcode | input | 4 | Macroinstruction opcode used by dispatch |
| ind_bit | input | 1 | Indirect mode bit of the macroinstruction |
| sign_flag | input | 1 | Sign status flag |
| zero_flag | input | 1 | Zero status flag |
| car | output | 7 | Control address register, drives the control store |

## Verification
The return register cannot be seen at the ports. Its contents, and the fact that it holds its value after a call that is not taken, show up only through a later return. The bench therefore runs chains of microinstructions: call, then a not-taken call, then a return. It also runs a reset in the middle of a subroutine followed by a dispatch into a slot holding a return. Flags and opcodes are chosen for each cycle so that both outcomes of every mode are reached, and a stretch of random flags then runs the whole test store against the reference model.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      BR_JMP  = 2'b00,
      BR_CALL = 2'b01,
      BR_RET  = 2'b10,
      BR_MAP  = 2'b11
   } br_mode_e;

   typedef enum logic [1:0] {
      CD_ALWAYS = 2'b00,
      CD_IND    = 2'b01,
      CD_SIGN   = 2'b10,
      CD_ZERO   = 2'b11
   } cd_sel_e;

   localparam int MODE_W = 2;
   localparam int CSEL_W = 2;
   localparam int NCOND  = 4;
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
   parameter int NCOND = 4,
   localparam int SEL_W = $clog2(NCOND)
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [NCOND-1:0] conds,
   output logic             hit
);
   logic [NCOND-1:0] gated;

   // one AND per source, then an OR tree
   for (genvar k = 0; k < NCOND; k++) begin : g_src
      assign gated[k] = conds[k] & (sel == SEL_W'(k));
   end

   assign hit = |gated;
endmodule

// File: rtl/useq_addr_gen.sv
module useq_addr_gen
   import useq_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int OP_W    = 4,
   parameter int MAP_LSB = 2
) (
   input  br_mode_e          mode,
   input  logic              hit,
   input  logic [ADDR_W-1:0] cur,
   input  logic [ADDR_W-1:0] target,
   input  logic [OP_W-1:0]   opcode,
   input  logic [ADDR_W-1:0] ret_val,
   output logic [ADDR_W-1:0] nxt,
   output logic              ret_load,
   output logic [ADDR_W-1:0] ret_next
);
   localparam int PAD_W = ADDR_W - OP_W - MAP_LSB;

   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] map_addr;

   assign inc = cur + ADDR_W'(1);

   if (PAD_W > 0) begin : g_map_pad
      assign map_addr = {{PAD_W{1'b0}}, opcode, {MAP_LSB{1'b0}}};
   end else begin : g_map_full
      assign map_addr = {opcode, {MAP_LSB{1'b0}}};
   end

   always_comb begin
      nxt      = inc;
      ret_load = 1'b0;
      ret_next = inc;
      unique case (mode)
         BR_JMP:  nxt = hit ? target : inc;
         BR_CALL: begin
            nxt      = hit ? target : inc;
            ret_load = hit;
         end
         BR_RET:  nxt = ret_val;
         BR_MAP:  nxt = map_addr;
         default: nxt = inc;
      endcase
   end
endmodule

// File: rtl/useq_ret_reg.sv
module useq_ret_reg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/uprog_sequencer.sv
module uprog_sequencer
   import useq_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int OP_W       = 4,
   parameter int MAP_LSB    = 2,
   parameter int UOP_FIELDS = 3,
   parameter int UOP_W      = 3,
   localparam int WORD_W    = UOP_FIELDS*UOP_W + CSEL_W + MODE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] uinstr,
   input  logic [OP_W-1:0]   opcode,
   input  logic              ind_bit,
   input  logic              sign_flag,
   input  logic              zero_flag,
   output logic [ADDR_W-1:0] car
);
   localparam int MODE_LSB = ADDR_W;
   localparam int CSEL_LSB = ADDR_W + MODE_W;
   localparam int UOP_LSB  = CSEL_LSB + CSEL_W;

   if (OP_W + MAP_LSB > ADDR_W) begin : g_bad_map
      $error("dispatch slot does not fit the control address");
   end
   if (UOP_FIELDS < 1 || UOP_W < 1) begin : g_bad_uop
      $error("micro-operation area must be non-empty");
   end

   logic [ADDR_W-1:0] target;
   br_mode_e          mode;
   logic [CSEL_W-1:0] csel;
   logic              uop_unused;
   logic              hit;
   logic [ADDR_W-1:0] nxt;
   logic              ret_load;
   logic [ADDR_W-1:0] ret_next;
   logic [ADDR_W-1:0] ret_q;

   assign target     = uinstr[ADDR_W-1:0];
   assign mode       = br_mode_e'(uinstr[MODE_LSB +: MODE_W]);
   assign csel       = uinstr[CSEL_LSB +: CSEL_W];
   assign uop_unused = ^uinstr[WORD_W-1:UOP_LSB];

   useq_cond_mux #(.NCOND(NCOND)) u_cond (
      .sel   (csel),
      .conds ({zero_flag, sign_flag, ind_bit, 1'b1}),
      .hit   (hit)
   );

   useq_addr_gen #(.ADDR_W(ADDR_W), .OP_W(OP_W), .MAP_LSB(MAP_LSB)) u_gen (
      .mode     (mode),
      .hit      (hit),
      .cur      (car),
      .target   (target),
      .opcode   (opcode),
      .ret_val  (ret_q),
      .nxt      (nxt),
      .ret_load (ret_load),
      .ret_next (ret_next)
   );

   useq_ret_reg #(.W(ADDR_W)) u_ret (
      .clk  (clk),
      .rst  (rst),
      .load (ret_load),
      .d    (ret_next),
      .q    (ret_q)
   );

   always_ff @(posedge clk) begin
      if (rst) car <= '0;
      else     car <= nxt;
   end
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
   parameter int ADDR_W  = 7,
   parameter int OP_W    = 4,
   parameter int MAP_LSB = 2,
   parameter int WORD_W  = 20
) (
   input logic              clk,
   input logic              rst,
   input logic [WORD_W-1:0] uinstr,
   input logic [OP_W-1:0]   opcode,
   input logic              ind_bit,
   input logic              sign_flag,
   input logic              zero_flag,
   input logic [ADDR_W-1:0] car,
   input logic [ADDR_W-1:0] ret_q
);
   logic [1:0]        md;
   logic [1:0]        cs;
   logic              c_ok;
   logic [ADDR_W-1:0] tgt;

   assign md  = uinstr[ADDR_W +: 2];
   assign cs  = uinstr[ADDR_W+2 +: 2];
   assign tgt = uinstr[ADDR_W-1:0];

   always_comb begin
      case (cs)
         2'd0:    c_ok = 1'b1;
         2'd1:    c_ok = ind_bit;
         2'd2:    c_ok = sign_flag;
         default: c_ok = zero_flag;
      endcase
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (car == '0 && ret_q == '0));

   // R5
   jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 2'd0 && c_ok) |=> car == $past(tgt));

   // R5
   jump_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 2'd0 && !c_ok) |=> car == ADDR_W'($past(car) + 1'b1));

   // R6
   call_link_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 2'd1 && c_ok) |=> (car == $past(tgt) && ret_q == ADDR_W'($past(car) + 1'b1)));

   // R6
   call_skip_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 2'd1 && !c_ok) |=> $stable(ret_q));

   // R7
   return_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 2'd2) |=> car == $past(ret_q));

   // R8
   dispatch_chk: assert property (@(posedge clk) disable iff (rst)
      (md == 2'd3) |=> car == ADDR_W'({$past(opcode), {MAP_LSB{1'b0}}}));
endmodule

bind uprog_sequencer useq_chk #(
   .ADDR_W(ADDR_W), .OP_W(OP_W), .MAP_LSB(MAP_LSB), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst(rst), .uinstr(uinstr), .opcode(opcode), .ind_bit(ind_bit),
   .sign_flag(sign_flag), .zero_flag(zero_flag), .car(car), .ret_q(ret_q)
);

// File: tb/uprog_sequencer_test.sv
`timescale 1ns/1ps
module uprog_sequencer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] uinstr;
   logic [3:0]  opcode = '0;
   logic        ind_bit = 1'b0, sign_flag = 1'b0, zero_flag = 1'b0;
   logic [6:0]  car;

   logic [19:0] rom [128];
   int          exp_car = 0;
   int          exp_ret = 0;
   int          tests = 0;
   int          fails = 0;

   always #5 clk = ~clk;

   assign uinstr = rom[car];

   uprog_sequencer uut (
      .clk(clk), .rst(rst), .uinstr(uinstr), .opcode(opcode),
      .ind_bit(ind_bit), .sign_flag(sign_flag), .zero_flag(zero_flag), .car(car)
   );

   // condition codes: 0 always, 1 I, 2 S, 3 Z; modes: 0 jump, 1 call, 2 return, 3 dispatch
   function automatic logic [19:0] mk(input int uops, input int cs, input int md, input int tg);
      logic [8:0] u = uops[8:0];
      logic [1:0] c = cs[1:0];
      logic [1:0] m = md[1:0];
      logic [6:0] t = tg[6:0];
      return {u, c, m, t};
   endfunction

   task automatic check(input string tag);
      tests++;
      if (car !== exp_car[6:0]) begin
         fails++;
         $display("FAIL %s: car actual=%0d expected=%0d", tag, car, exp_car);
      end
   endtask

   task automatic step(input logic i_b, input logic s_b, input logic z_b,
                       input int op, input string tag);
      logic [19:0] w;
      int c, nxt, nret, inc;
      ind_bit = i_b; sign_flag = s_b; zero_flag = z_b; opcode = op[3:0];
      w    = rom[exp_car];
      case (int'(w[10:9]))
         0: c = 1;
         1: c = i_b;
         2: c = s_b;
         default: c = z_b;
      endcase
      inc  = (exp_car + 1) % 128;
      nxt  = inc;
      nret = exp_ret;
      case (int'(w[8:7]))
         0: nxt = c ? int'(w[6:0]) : inc;
         1: if (c) begin nxt = int'(w[6:0]); nret = inc; end
         2: nxt = exp_ret;
         default: nxt = (op % 16) * 4;
      endcase
      @(posedge clk);
      @(negedge clk);
      exp_car = nxt;
      exp_ret = nret;
      check(tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exp_car = 0;
      exp_ret = 0;
      check("R1");
      rst = 1'b0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog R1..: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 128; k++) rom[k] = '0;
      rom[0]    = mk(9'o210, 1, 0, 7'h10);  // I ? 0x10 : 1
      rom[1]    = mk(0,      0, 3, 0);      // dispatch
      rom[7'h10]= mk(0,      0, 0, 7'h01);
      rom[12]   = mk(0,      2, 1, 7'h40);  // S ? call 0x40
      rom[13]   = mk(0,      0, 0, 0);
      rom[7'h40]= mk(0,      3, 2, 7'h55);  // return, target ignored
      rom[20]   = mk(0,      3, 0, 7'h30);  // Z ? 0x30 : 21
      rom[21]   = mk(0,      1, 3, 0);      // dispatch with I tested
      rom[28]   = mk(0,      0, 2, 0);      // return
      rom[7'h30]= mk(9'h1FF, 0, 0, 7'h7F);  // all uop bits set
      rom[7'h7F]= mk(0,      3, 0, 7'h22);  // Z ? 0x22 : wrap
      rom[60]   = mk(0,      0, 1, 7'h7E);  // call 0x7E
      rom[7'h7E]= mk(0,      2, 2, 0);      // return with S tested
      rom[61]   = mk(0,      2, 1, 7'h20);  // S ? call 0x20 : 62
      rom[62]   = mk(0,      0, 2, 0);

      @(negedge clk);
      do_reset();
      step(0, 0, 0, 3, "R5");   // 0 -> 1, I false
      step(0, 0, 0, 3, "R8");   // 1 -> 12
      step(0, 1, 0, 3, "R4");   // S true call -> 0x40
      step(0, 0, 0, 3, "R7");   // return -> 13
      step(0, 0, 0, 3, "R3");   // -> 0
      step(1, 0, 0, 3, "R4");   // I true -> 0x10
      step(0, 0, 0, 5, "R3");   // -> 1
      step(0, 0, 0, 5, "R8");   // -> 20
      step(0, 0, 1, 5, "R4");   // Z true -> 0x30
      step(1, 1, 1, 5, "R2");   // -> 0x7F
      step(0, 0, 0, 5, "R9");   // wrap -> 0
      step(0, 0, 0, 5, "R5");   // -> 1
      step(0, 0, 0, 5, "R8");   // -> 20
      step(0, 0, 0, 5, "R5");   // Z false -> 21
      step(0, 0, 0, 15, "R8");  // -> 60
      step(0, 0, 0, 15, "R6");  // call -> 0x7E
      step(0, 1, 1, 15, "R7");  // return -> 61
      step(0, 0, 0, 15, "R6");  // call not taken -> 62
      step(0, 0, 0, 15, "R6");  // return -> 61, link unchanged
      do_reset();
      step(0, 0, 0, 7, "R5");   // -> 1
      step(0, 0, 0, 7, "R8");   // -> 28
      step(0, 0, 0, 7, "R1");   // return -> 0 after reset
      for (int n = 0; n < 400; n++) begin
         int r = $urandom;
         step(r[0], r[1], r[2], (r >> 3) % 16, "R5");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule